// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block drives a parallel RGB LCD panel from a fast system clock. It divides the fast clock into pixel periods. It walks a horizontal pixel counter and a vertical line counter, and from them it produces the pixel clock, the horizontal and vertical sync pulses, the data-enable window and the coordinates of the active pixel. A pixel source outside the block watches the request strobe and the coordinates, and returns colour data in the same cycle. The block registers that data onto the panel colour bus. It can stagger the red, green and blue groups by one fast cycle each, so that fewer colour lines switch together.

Software programs the timing through a write-only port. A divisor of zero stops all scan-out and holds the panel lines idle. Every other setting is copied into a shadow set at a frame boundary, so a write during a frame takes effect on the next frame only. A swap request for a double-buffered display list is also held until the next frame boundary. At that boundary the block toggles its active-buffer output.

The control core is a three-state machine. OFF is the suspended state. START is a single load cycle. SCAN is normal raster operation. The transitions are:
- ENABLE: OFF→START, when the live divisor is non-zero.
- BEGIN: START→SCAN, which loads the shadows.
- WRAP: SCAN→SCAN on the last fast cycle of the last pixel of the frame, which loads the shadows and applies a pending swap.
- HALT: START or SCAN→OFF, whenever the live divisor is zero.

Top module: `lcd_raster_timer`

## Requirements
- R1: The register write address map is: 0 divisor, 1 clock polarity (bit 0), 2 colour stagger enable (bit 0), 3 swap request, 4 line total, 5 horizontal offset, 6 horizontal active width, 7 HSYNC fall position, 8 HSYNC rise position, 9 frame total in lines, 10 vertical offset, 11 vertical active height, 12 VSYNC fall line, 13 VSYNC rise line. Writes to addresses 14 and 15 have no effect.
- R2: While the live divisor is zero, the outputs are held idle: lcd_de=0, lcd_hsync_n=1, lcd_vsync_n=1, lcd_pclk=0, pclk_en=0, pix_req=0, lcd_rgb=0. Writing 0 during a scan makes the outputs idle from the second clock edge after the write edge.
- R3: After a non-zero divisor D is written from the idle state, scanning begins two clock edges after the write edge, at pixel (0,0) with the divider phase at 0. pclk_en then pulses for one fast cycle at phase 0 of every D-cycle pixel period.
- R4: With polarity 0, lcd_pclk is high in the phases p of a pixel period where p >= floor(D/2), and low otherwise. Polarity 1 inverts lcd_pclk.
- R5: A line lasts the line-total number of pixel periods. A frame lasts the frame-total number of lines, and the pixel and line counters both return to 0 together at the frame end.
- R6: lcd_hsync_n is low exactly for pixel counts h with fall <= h < rise. lcd_vsync_n is low exactly for line counts v with fall <= v < rise.
- R7: lcd_de is high exactly when hoff <= h < hoff+hact and voff <= v < voff+vact. While lcd_de is high, pix_x=h-hoff and pix_y=v-voff; otherwise both are 0. pix_req equals pclk_en AND lcd_de.
- R8: With stagger disabled, colour data presented on pix_rgb during a pclk_en cycle appears on all of lcd_rgb in the next cycle. lcd_rgb is red in the top COLOR_W bits, then green, then blue. A pixel outside the active window is output as 0.
- R9: With stagger enabled, the red group updates 1 cycle after pclk_en, the green group 2 cycles after and the blue group 3 cycles after, each carrying the same pixel's value.
- R10: Writing 2 to the swap address sets swap_pending in the next cycle; other values written there are ignored. At the next frame boundary, disp_buf toggles and swap_pending returns to 0.
- R11: Timing, polarity, stagger and divisor values written during a frame take effect only from the first pixel of the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | LRT_CW | Register write data |
| pix_rgb | input | 3*COLOR_W | Colour of the requested pixel, same cycle as the request |
| lcd_pclk | output | 1 | Pixel clock to the panel |
| lcd_hsync_n | output | 1 | Horizontal sync, active low |
| lcd_vsync_n | output | 1 | Vertical sync, active low |
| lcd_de | output | 1 | Data enable |
| lcd_rgb | output | 3*COLOR_W | Colour bus to the panel |
| pclk_en | output | 1 | One-cycle strobe at the start of each pixel period |
| pix_req | output | 1 | Request for the colour of the pixel at pix_x/pix_y |
| pix_x | output | LRT_CW | Active-area column |
| pix_y | output | LRT_CW | Active-area row |
| swap_pending | output | 1 | Swap request waiting for the frame boundary |
| disp_buf | output | 1 | Index of the active display-list buffer |

## Verification
The bench sweeps every fast cycle of several complete frames of a small raster, a 10- or 12-pixel line by 6 lines with a divisor of 3, and compares every output against positions it computes arithmetically.

The first frame runs with default polarity and no stagger. This separates the sync window edges from the data-enable edges, and in-window pixels from out-of-window pixels, whose colour must be 0.

Mid-frame writes to the line total, the active width, the polarity and the stagger enable check that nothing changes before the frame boundary. The frames that follow then run under the new settings.

A coordinate-dependent colour pattern with stagger enabled checks that each group lags by its own number of cycles. Swap writes of 1 and 2, a write to an unused address, and a final zero divisor cover the ignored cases and the idle state.

// File: rtl/lrt_pkg.sv
package lrt_pkg;

    localparam int LRT_CW = 12;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_START = 2'd1,
        ST_SCAN  = 2'd2
    } scan_state_e;

    typedef enum logic [3:0] {
        RA_DIV    = 4'd0,
        RA_POL    = 4'd1,
        RA_SPREAD = 4'd2,
        RA_SWAP   = 4'd3,
        RA_HTOT   = 4'd4,
        RA_HOFF   = 4'd5,
        RA_HACT   = 4'd6,
        RA_HFALL  = 4'd7,
        RA_HRISE  = 4'd8,
        RA_VTOT   = 4'd9,
        RA_VOFF   = 4'd10,
        RA_VACT   = 4'd11,
        RA_VFALL  = 4'd12,
        RA_VRISE  = 4'd13
    } reg_addr_e;

    localparam logic [LRT_CW-1:0] SWAP_CODE = LRT_CW'(2);

    typedef struct packed {
        logic [LRT_CW-1:0] div;
        logic              pol;
        logic              spread;
        logic [LRT_CW-1:0] htot;
        logic [LRT_CW-1:0] hoff;
        logic [LRT_CW-1:0] hact;
        logic [LRT_CW-1:0] hfall;
        logic [LRT_CW-1:0] hrise;
        logic [LRT_CW-1:0] vtot;
        logic [LRT_CW-1:0] voff;
        logic [LRT_CW-1:0] vact;
        logic [LRT_CW-1:0] vfall;
        logic [LRT_CW-1:0] vrise;
    } timing_t;

endpackage

// File: rtl/lrt_regbank.sv
module lrt_regbank
    import lrt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [LRT_CW-1:0] wr_data,
    input  logic              frame_load,
    output timing_t           live,
    output timing_t           shadow,
    output logic              swap_pending,
    output logic              disp_buf
);

    logic swap_hit;
    assign swap_hit = wr_en && (wr_addr == RA_SWAP) && (wr_data == SWAP_CODE);

    // live register file, written by software at any time
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                RA_DIV:    live.div    <= wr_data;
                RA_POL:    live.pol    <= wr_data[0];
                RA_SPREAD: live.spread <= wr_data[0];
                RA_HTOT:   live.htot   <= wr_data;
                RA_HOFF:   live.hoff   <= wr_data;
                RA_HACT:   live.hact   <= wr_data;
                RA_HFALL:  live.hfall  <= wr_data;
                RA_HRISE:  live.hrise  <= wr_data;
                RA_VTOT:   live.vtot   <= wr_data;
                RA_VOFF:   live.voff   <= wr_data;
                RA_VACT:   live.vact   <= wr_data;
                RA_VFALL:  live.vfall  <= wr_data;
                RA_VRISE:  live.vrise  <= wr_data;
                default:   ;
            endcase
        end
    end

    // shadow set, refreshed only at a frame boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (frame_load) begin
            shadow <= live;
        end
    end

    // deferred buffer swap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            swap_pending <= 1'b0;
            disp_buf     <= 1'b0;
        end else begin
            if (frame_load && swap_pending) begin
                disp_buf     <= ~disp_buf;
                swap_pending <= 1'b0;
            end
            if (swap_hit) begin
                swap_pending <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/lrt_scan_fsm.sv
module lrt_scan_fsm
    import lrt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              live_div_nz,
    input  logic [LRT_CW-1:0] sh_div,
    input  logic [LRT_CW-1:0] sh_htot,
    input  logic [LRT_CW-1:0] sh_vtot,
    output scan_state_e       state_q,
    output logic [LRT_CW-1:0] dcnt,
    output logic [LRT_CW-1:0] hcnt,
    output logic [LRT_CW-1:0] vcnt,
    output logic              scan_active,
    output logic              pclk_en,
    output logic              frame_load
);

    scan_state_e state_d;
    logic        tick;
    logic        h_last;
    logic        v_last;

    assign tick   = (dcnt == sh_div - LRT_CW'(1));
    assign h_last = (hcnt == sh_htot - LRT_CW'(1));
    assign v_last = (vcnt == sh_vtot - LRT_CW'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and control outputs
    always_comb begin
        state_d     = state_q;
        frame_load  = 1'b0;
        scan_active = 1'b0;
        pclk_en     = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (live_div_nz) begin
                    state_d = ST_START;              // ENABLE
                end
            end
            ST_START: begin
                if (!live_div_nz) begin
                    state_d = ST_OFF;                // HALT
                end else begin
                    state_d    = ST_SCAN;            // BEGIN
                    frame_load = 1'b1;
                end
            end
            ST_SCAN: begin
                scan_active = 1'b1;
                pclk_en     = (dcnt == '0);
                if (!live_div_nz) begin
                    state_d = ST_OFF;                // HALT
                end else if (tick && h_last && v_last) begin
                    frame_load = 1'b1;               // WRAP
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // divider and raster counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dcnt <= '0;
            hcnt <= '0;
            vcnt <= '0;
        end else if (state_q != ST_SCAN) begin
            dcnt <= '0;
            hcnt <= '0;
            vcnt <= '0;
        end else if (!tick) begin
            dcnt <= dcnt + LRT_CW'(1);
        end else begin
            dcnt <= '0;
            if (!h_last) begin
                hcnt <= hcnt + LRT_CW'(1);
            end else begin
                hcnt <= '0;
                vcnt <= v_last ? '0 : vcnt + LRT_CW'(1);
            end
        end
    end

endmodule

// File: rtl/lrt_sync_decode.sv
module lrt_sync_decode
    import lrt_pkg::*;
(
    input  logic              scan_active,
    input  logic [LRT_CW-1:0] dcnt,
    input  logic [LRT_CW-1:0] hcnt,
    input  logic [LRT_CW-1:0] vcnt,
    input  logic [LRT_CW-1:0] div,
    input  logic              pol,
    input  logic [LRT_CW-1:0] hoff,
    input  logic [LRT_CW-1:0] hact,
    input  logic [LRT_CW-1:0] hfall,
    input  logic [LRT_CW-1:0] hrise,
    input  logic [LRT_CW-1:0] voff,
    input  logic [LRT_CW-1:0] vact,
    input  logic [LRT_CW-1:0] vfall,
    input  logic [LRT_CW-1:0] vrise,
    output logic              lcd_pclk,
    output logic              lcd_hsync_n,
    output logic              lcd_vsync_n,
    output logic              lcd_de,
    output logic [LRT_CW-1:0] pix_x,
    output logic [LRT_CW-1:0] pix_y
);

    localparam int EW = LRT_CW + 1;

    logic [EW-1:0] h_end;
    logic [EW-1:0] v_end;
    logic          h_win;
    logic          v_win;
    logic          hs_low;
    logic          vs_low;

    assign h_end  = {1'b0, hoff} + {1'b0, hact};
    assign v_end  = {1'b0, voff} + {1'b0, vact};
    assign h_win  = (hcnt >= hoff) && ({1'b0, hcnt} < h_end);
    assign v_win  = (vcnt >= voff) && ({1'b0, vcnt} < v_end);
    assign hs_low = (hcnt >= hfall) && (hcnt < hrise);
    assign vs_low = (vcnt >= vfall) && (vcnt < vrise);

    always_comb begin
        lcd_de      = scan_active && h_win && v_win;
        lcd_hsync_n = !(scan_active && hs_low);
        lcd_vsync_n = !(scan_active && vs_low);
        lcd_pclk    = scan_active && ((dcnt >= (div >> 1)) ^ pol);
        pix_x       = lcd_de ? (hcnt - hoff) : '0;
        pix_y       = lcd_de ? (vcnt - voff) : '0;
    end

endmodule

// File: rtl/lrt_color_stage.sv
module lrt_color_stage #(
    parameter int COLOR_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scan_active,
    input  logic                 spread,
    input  logic                 pclk_en,
    input  logic                 lcd_de,
    input  logic [3*COLOR_W-1:0] pix_rgb,
    output logic [3*COLOR_W-1:0] lcd_rgb
);

    localparam int GROUPS = 3;
    localparam int RGB_W  = GROUPS * COLOR_W;

    logic             en_p  [GROUPS];
    logic [RGB_W-1:0] val_p [GROUPS];

    assign en_p[0]  = pclk_en;
    assign val_p[0] = lcd_de ? pix_rgb : '0;

    // delay line: stage k holds the capture strobe and value k cycles late
    for (genvar k = 1; k < GROUPS; k++) begin : g_pipe
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_p[k]  <= 1'b0;
                val_p[k] <= '0;
            end else if (!scan_active) begin
                en_p[k]  <= 1'b0;
                val_p[k] <= '0;
            end else begin
                en_p[k]  <= en_p[k-1];
                val_p[k] <= val_p[k-1];
            end
        end
    end

    // group g (0 red, 1 green, 2 blue) uses stage g when staggered
    for (genvar g = 0; g < GROUPS; g++) begin : g_group
        localparam int LSB = (GROUPS - 1 - g) * COLOR_W;
        logic sel_en;
        logic [COLOR_W-1:0] sel_val;
        always_comb begin
            if (spread) begin
                sel_en  = en_p[g];
                sel_val = val_p[g][LSB +: COLOR_W];
            end else begin
                sel_en  = en_p[0];
                sel_val = val_p[0][LSB +: COLOR_W];
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lcd_rgb[LSB +: COLOR_W] <= '0;
            end else if (!scan_active) begin
                lcd_rgb[LSB +: COLOR_W] <= '0;
            end else if (sel_en) begin
                lcd_rgb[LSB +: COLOR_W] <= sel_val;
            end
        end
    end

endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
    import lrt_pkg::*;
#(
    parameter int COLOR_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [3:0]           wr_addr,
    input  logic [LRT_CW-1:0]    wr_data,
    input  logic [3*COLOR_W-1:0] pix_rgb,
    output logic                 lcd_pclk,
    output logic                 lcd_hsync_n,
    output logic                 lcd_vsync_n,
    output logic                 lcd_de,
    output logic [3*COLOR_W-1:0] lcd_rgb,
    output logic                 pclk_en,
    output logic                 pix_req,
    output logic [LRT_CW-1:0]    pix_x,
    output logic [LRT_CW-1:0]    pix_y,
    output logic                 swap_pending,
    output logic                 disp_buf
);

    timing_t           live;
    timing_t           shadow;
    scan_state_e       state_q;
    logic [LRT_CW-1:0] dcnt;
    logic [LRT_CW-1:0] hcnt;
    logic [LRT_CW-1:0] vcnt;
    logic              scan_active;
    logic              frame_load;

    lrt_regbank u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .frame_load   (frame_load),
        .live         (live),
        .shadow       (shadow),
        .swap_pending (swap_pending),
        .disp_buf     (disp_buf)
    );

    lrt_scan_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .live_div_nz (live.div != '0),
        .sh_div      (shadow.div),
        .sh_htot     (shadow.htot),
        .sh_vtot     (shadow.vtot),
        .state_q     (state_q),
        .dcnt        (dcnt),
        .hcnt        (hcnt),
        .vcnt        (vcnt),
        .scan_active (scan_active),
        .pclk_en     (pclk_en),
        .frame_load  (frame_load)
    );

    lrt_sync_decode u_dec (
        .scan_active (scan_active),
        .dcnt        (dcnt),
        .hcnt        (hcnt),
        .vcnt        (vcnt),
        .div         (shadow.div),
        .pol         (shadow.pol),
        .hoff        (shadow.hoff),
        .hact        (shadow.hact),
        .hfall       (shadow.hfall),
        .hrise       (shadow.hrise),
        .voff        (shadow.voff),
        .vact        (shadow.vact),
        .vfall       (shadow.vfall),
        .vrise       (shadow.vrise),
        .lcd_pclk    (lcd_pclk),
        .lcd_hsync_n (lcd_hsync_n),
        .lcd_vsync_n (lcd_vsync_n),
        .lcd_de      (lcd_de),
        .pix_x       (pix_x),
        .pix_y       (pix_y)
    );

    lrt_color_stage #(.COLOR_W(COLOR_W)) u_color (
        .clk         (clk),
        .rst_n       (rst_n),
        .scan_active (scan_active),
        .spread      (shadow.spread),
        .pclk_en     (pclk_en),
        .lcd_de      (lcd_de),
        .pix_rgb     (pix_rgb),
        .lcd_rgb     (lcd_rgb)
    );

    assign pix_req = pclk_en && lcd_de;

endmodule

// File: rtl/lrt_checks.sv
module lrt_checks
    import lrt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              scan_active,
    input logic              frame_load,
    input logic [LRT_CW-1:0] sh_div,
    input logic [LRT_CW-1:0] sh_htot,
    input logic              wr_en,
    input logic [3:0]        wr_addr,
    input logic [LRT_CW-1:0] wr_data,
    input logic              pclk_en,
    input logic              pix_req,
    input logic              lcd_de,
    input logic              lcd_hsync_n,
    input logic              lcd_vsync_n,
    input logic              lcd_pclk,
    input logic [LRT_CW-1:0] pix_x,
    input logic [LRT_CW-1:0] pix_y,
    input logic              swap_pending,
    input logic              disp_buf
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_active |-> (!lcd_de && lcd_hsync_n && lcd_vsync_n && !lcd_pclk && !pclk_en)); // R2

    AST_PCLK_EN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pclk_en && sh_div > LRT_CW'(1)) |=> !pclk_en); // R3

    AST_REQ_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        pix_req |-> (lcd_de && pclk_en)); // R7

    AST_XY_ZERO_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_de |-> (pix_x == '0 && pix_y == '0)); // R7

    AST_SWAP_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 4'd3 && wr_data == LRT_CW'(2)) |=> swap_pending); // R10

    AST_BUF_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_load |=> $stable(disp_buf)); // R10

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_load |=> ($stable(sh_htot) && $stable(sh_div))); // R11

endmodule

bind lcd_raster_timer lrt_checks u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .scan_active  (scan_active),
    .frame_load   (frame_load),
    .sh_div       (shadow.div),
    .sh_htot      (shadow.htot),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .pclk_en      (pclk_en),
    .pix_req      (pix_req),
    .lcd_de       (lcd_de),
    .lcd_hsync_n  (lcd_hsync_n),
    .lcd_vsync_n  (lcd_vsync_n),
    .lcd_pclk     (lcd_pclk),
    .pix_x        (pix_x),
    .pix_y        (pix_y),
    .swap_pending (swap_pending),
    .disp_buf     (disp_buf)
);

// File: tb/tb_lcd_raster_timer.sv
module tb_lcd_raster_timer;
    import lrt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int W = 6;
    localparam int RW = 3 * W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [3:0]        wr_addr = '0;
    logic [LRT_CW-1:0] wr_data = '0;
    logic [RW-1:0]     pix_rgb;
    logic              lcd_pclk, lcd_hsync_n, lcd_vsync_n, lcd_de;
    logic [RW-1:0]     lcd_rgb;
    logic              pclk_en, pix_req, swap_pending, disp_buf;
    logic [LRT_CW-1:0] pix_x, pix_y;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_raster_timer #(.COLOR_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pix_rgb(pix_rgb), .lcd_pclk(lcd_pclk), .lcd_hsync_n(lcd_hsync_n),
        .lcd_vsync_n(lcd_vsync_n), .lcd_de(lcd_de), .lcd_rgb(lcd_rgb),
        .pclk_en(pclk_en), .pix_req(pix_req), .pix_x(pix_x), .pix_y(pix_y),
        .swap_pending(swap_pending), .disp_buf(disp_buf)
    );

    // pixel source: colour depends on the requested coordinates
    always_comb begin
        pix_rgb = {W'(pix_x + 1), W'(pix_y + 3), W'(pix_x + pix_y + 5)};
    end

    // bench mirror of written registers and of the frame-level shadows
    int lv [16];
    int sd, sp, ss, sht, sho, sha, shf, shr, svt, svo, sva, svf, svr;
    int mdc, mh, mv;
    bit pend, bufm;
    logic [RW-1:0] prev_v, cur_v;

    task automatic chk(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit fde(int h, int v);
        return (h >= sho) && (h < sho + sha) && (v >= svo) && (v < svo + sva);
    endfunction

    function automatic logic [RW-1:0] vcalc(int h, int v);
        int x, y;
        if (!fde(h, v)) return '0;
        x = h - sho;
        y = v - svo;
        return {W'(x + 1), W'(y + 3), W'(x + y + 5)};
    endfunction

    task automatic load_shadows();
        sd = lv[0]; sp = lv[1]; ss = lv[2];
        sht = lv[4]; sho = lv[5]; sha = lv[6]; shf = lv[7]; shr = lv[8];
        svt = lv[9]; svo = lv[10]; sva = lv[11]; svf = lv[12]; svr = lv[13];
    endtask

    task automatic note_write(int a, int d);
        if (a < 14) lv[a] = d;
        if (a == 3 && d == 2) pend = 1'b1;
    endtask

    task automatic check_idle(string tag);
        chk(tag, "de", lcd_de, 0);
        chk(tag, "hsync_n", lcd_hsync_n, 1);
        chk(tag, "vsync_n", lcd_vsync_n, 1);
        chk(tag, "pclk", lcd_pclk, 0);
        chk(tag, "pclk_en", pclk_en, 0);
        chk(tag, "pix_req", pix_req, 0);
        chk(tag, "rgb", lcd_rgb, 0);
    endtask

    // single write while idle; leaves the strobe asserted for one edge
    task automatic put(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = LRT_CW'(d);
        note_write(a, d);
    endtask

    // one fast cycle of the scanning model: check, advance, drive
    task automatic step(bit w, int a, int d);
        bit de_e;
        int thr;
        @(negedge clk);
        de_e = fde(mh, mv);
        chk("R3", "pclk_en", pclk_en, (mdc == 0));
        chk("R4", "pclk", lcd_pclk, int'((mdc >= sd / 2) ^ sp[0]));
        chk("R6", "hsync_n", lcd_hsync_n, int'(!(mh >= shf && mh < shr)));
        chk("R6", "vsync_n", lcd_vsync_n, int'(!(mv >= svf && mv < svr)));
        chk("R7", "de", lcd_de, de_e);
        chk("R7", "pix_req", pix_req, int'(de_e && mdc == 0));
        chk("R7", "pix_x", pix_x, de_e ? mh - sho : 0);
        chk("R7", "pix_y", pix_y, de_e ? mv - svo : 0);
        for (int g = 0; g < 3; g++) begin
            int lsb = (2 - g) * W;
            thr = (ss != 0) ? g + 1 : 1;
            chk((ss != 0) ? "R9" : "R8", "rgb group", lcd_rgb[lsb +: W],
                (mdc >= thr) ? cur_v[lsb +: W] : prev_v[lsb +: W]);
        end
        chk("R10", "swap_pending", swap_pending, pend);
        chk("R10", "disp_buf", disp_buf, bufm);
        // advance model across the coming edge (R5, R11)
        if (mdc == sd - 1) begin
            mdc = 0;
            if (mh == sht - 1) begin
                mh = 0;
                if (mv == svt - 1) begin
                    mv = 0;
                    load_shadows();
                    if (pend) begin bufm = ~bufm; pend = 1'b0; end
                end else begin
                    mv++;
                end
            end else begin
                mh++;
            end
            prev_v = cur_v;
            cur_v  = vcalc(mh, mv);
        end else begin
            mdc++;
        end
        wr_en = w; wr_addr = 4'(a); wr_data = LRT_CW'(d);
        if (w) note_write(a, d);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) lv[i] = 0;
        pend = 1'b0; bufm = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R2 reset");
        chk("R10 reset", "disp_buf", disp_buf, 0);
        chk("R10 reset", "swap_pending", swap_pending, 0);

        // timing programmed while the divisor is still zero (R1)
        put(4, 10); put(5, 2); put(6, 5); put(7, 1); put(8, 3);
        put(9, 6);  put(10, 1); put(11, 3); put(12, 4); put(13, 5);
        @(negedge clk);
        wr_en = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check_idle("R2 zero divisor");
        end

        // enable: divisor 3
        put(0, 3);
        @(negedge clk);
        wr_en = 1'b0;
        check_idle("R3 before start");
        @(negedge clk);
        check_idle("R3 start cycle");
        load_shadows();
        mdc = 0; mh = 0; mv = 0;
        prev_v = '0;
        cur_v  = vcalc(0, 0);

        for (int k = 0; k < 902; k++) begin
            case (k)
                20:  step(1, 3, 1);      // R10 ignored swap value
                40:  step(1, 3, 2);      // R10 swap request
                60:  step(1, 15, 7);     // R1 unused address
                100: step(1, 4, 12);     // R11 line total, deferred
                101: step(1, 6, 6);      // R11 active width, deferred
                420: step(1, 1, 1);      // R4 polarity, deferred
                421: step(1, 2, 1);      // R9 stagger, deferred
                422: step(1, 3, 2);      // R10 second swap
                900: step(1, 0, 0);      // R2 halt
                default: step(0, 0, 0);
            endcase
        end
        wr_en = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            check_idle("R2 halt");
        end
        chk("R10 after halt", "disp_buf", disp_buf, bufm);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule